// File: doc/BRIEF.md
# Fixed-Priority Video Memory Arbiter

This block decides which of five agents may use a shared video memory bank in each memory cycle. The agents are the display refresh fetch, DRAM refresh, slow expansion-slot DMA, the processor, and fast DMA. They are ranked in that order, highest first. The winner is chosen once, at the start of a memory cycle. It then holds the bank for a fixed number of clocks and is never preempted. A fixed gap of precharge clocks follows before the next cycle can begin.

DRAM refresh cycles use CAS-before-RAS. The arbiter therefore raises a refresh-type flag while refresh owns the bank and supplies no row address. When the processor asks for memory and does not hold the grant, the processor ready line is pulled low so that the processor adds wait states. Ready rises again in the same clock in which the processor grant appears.

A DRAM refresh request that has waited at least a programmable number of clocks is promoted to the very top, above the display fetch, so that steady display traffic cannot starve refresh. The block runs from the memory cycle clock (3.58 MHz in the intended system). It does not produce memory addresses, shift-register control or display timing.

The control is a three-state machine:
- ST_IDLE: no cycle is in progress.
- ST_RUN: a granted memory cycle is in progress.
- ST_GAP: precharge clocks after a cycle.

Its transitions are:
- start: ST_IDLE to ST_RUN, when any request is present.
- hold: ST_RUN to ST_RUN, counting clocks.
- release: ST_RUN to ST_GAP, after the last run clock.
- chain: ST_GAP to ST_RUN, at the end of the gap with a request pending.
- rest: ST_GAP to ST_IDLE, at the end of the gap with no request.
- wait: ST_IDLE to ST_IDLE, while nothing is requested.

Top module: `vma_arbiter`

## Requirements
- R1: Requester index encoding on `req` and `gnt` is bit 0 display fetch, bit 1 DRAM refresh, bit 2 slow DMA, bit 3 processor, bit 4 fast DMA. Unless refresh is promoted (R7), the lowest-numbered requester sampled at a cycle start wins.
- R2: `gnt` is one-hot or zero in every clock.
- R3: A granted cycle holds the same grant for exactly CYC_CLKS clocks without preemption. It is followed by exactly PRE_CLKS clocks with no grant. If a request is pending at the end of that gap, the next cycle starts at once.
- R4: `cpu_rdy` is low in exactly those clocks where bit 3 of `req` is high and bit 3 of `gnt` is low. It is high in the first clock of a processor grant.
- R5: `refresh_cbr` is high exactly while bit 1 of `gnt` is high.
- R6: `mem_strobe` is high exactly while some grant is active.
- R7: A wait counter advances once per clock while a refresh request is pending and not granted. It clears when refresh is granted or not requested. At a cycle start, if the counter is at least `age_limit`, refresh wins over every other requester, the display fetch included. An `age_limit` of 0 makes any refresh request win at once.
- R8: With no request present the arbiter stays idle, with `gnt` zero and `mem_strobe` low.
- R9: In reset and just after it, `gnt` is zero, `mem_strobe` and `refresh_cbr` are low, and `cpu_rdy` is high while the processor is not requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 5 | Request lines, one per requester (encoding in R1) |
| age_limit | input | AGE_W | Refresh wait threshold for promotion |
| gnt | output | 5 | One-hot grant, same encoding as `req` |
| refresh_cbr | output | 1 | High during a CAS-before-RAS refresh cycle |
| cpu_rdy | output | 1 | Processor ready; low inserts a wait state |
| mem_strobe | output | 1 | Memory cycle timing strobe, high while a cycle runs |

## Verification
The bench builds the arbiter with CYC_CLKS = 3, PRE_CLKS = 1 and AGE_W = 6. With these values each memory cycle takes four clocks. A refresh that waits behind a steady display fetch therefore crosses a limit of 6 at the third cycle start. This lets the bench contrast the promoted order with the unpromoted one (limit 63), and the immediate-promotion case (limit 0), within a few cycles. The short cycle also lets one burst of all five requesters walk the full priority order in twenty clocks. During that burst the processor's wait states are observed across three lost cycles.

// File: rtl/vma_pkg.sv
package vma_pkg;

    localparam int NREQ     = 5;
    localparam int IDX_VID  = 0;
    localparam int IDX_REF  = 1;
    localparam int IDX_SLOW = 2;
    localparam int IDX_CPU  = 3;
    localparam int IDX_FAST = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } cyc_state_e;

endpackage

// File: rtl/vma_pick.sv
module vma_pick
    import vma_pkg::*;
(
    input  logic [NREQ-1:0] req,
    input  logic            promote,
    output logic [NREQ-1:0] win,
    output logic            any
);

    logic hit;

    // Lowest index wins; an aged refresh jumps to the front.
    always_comb begin
        win = '0;
        hit = 1'b0;
        any = |req;
        if (promote && req[IDX_REF]) begin
            win[IDX_REF] = 1'b1;
            hit          = 1'b1;
        end else begin
            for (int i = 0; i < NREQ; i++) begin
                if (req[i] && !hit) begin
                    win[i] = 1'b1;
                    hit    = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vma_age.sv
module vma_age #(
    parameter int AGE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_req,
    input  logic             ref_gnt,
    input  logic [AGE_W-1:0] limit,
    output logic             aged
);

    logic [AGE_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (!ref_req || ref_gnt) begin
            wait_cnt <= '0;
        end else if (wait_cnt != '1) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    always_comb begin
        aged = ref_req && (wait_cnt >= limit);
    end

    AST_AGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |=> (wait_cnt == '0)); // R7

endmodule

// File: rtl/vma_cycle_fsm.sv
module vma_cycle_fsm
    import vma_pkg::*;
#(
    parameter int CYC_CLKS = 3,
    parameter int PRE_CLKS = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any,
    input  logic [NREQ-1:0] win,
    output logic [NREQ-1:0] gnt,
    output logic            active
);

    localparam int LONGEST = (CYC_CLKS > PRE_CLKS) ? CYC_CLKS : PRE_CLKS;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] CYC_LAST = CNT_W'(CYC_CLKS - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CLKS - 1);

    cyc_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [NREQ-1:0]  owner;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            owner <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (any) begin              // start
                        state <= ST_RUN;
                        owner <= win;
                        cnt   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt == CYC_LAST) begin  // release
                        state <= ST_GAP;
                        cnt   <= '0;
                    end else begin              // hold
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == PRE_LAST) begin
                        cnt <= '0;
                        if (any) begin          // chain
                            state <= ST_RUN;
                            owner <= win;
                        end else begin          // rest
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output process
    always_comb begin
        active = (state == ST_RUN);
        gnt    = active ? owner : '0;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R2

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cnt != CYC_LAST) |=> ($stable(gnt) && (gnt != '0))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !any) |=> (gnt == '0)); // R8

endmodule

// File: rtl/vma_arbiter.sv
module vma_arbiter
    import vma_pkg::*;
#(
    parameter int CYC_CLKS = 3,
    parameter int PRE_CLKS = 1,
    parameter int AGE_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       req,
    input  logic [AGE_W-1:0] age_limit,
    output logic [4:0]       gnt,
    output logic             refresh_cbr,
    output logic             cpu_rdy,
    output logic             mem_strobe
);

    logic            aged;
    logic            any;
    logic [NREQ-1:0] win;

    vma_age #(.AGE_W(AGE_W)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_req (req[IDX_REF]),
        .ref_gnt (gnt[IDX_REF]),
        .limit   (age_limit),
        .aged    (aged)
    );

    vma_pick u_pick (
        .req     (req),
        .promote (aged),
        .win     (win),
        .any     (any)
    );

    vma_cycle_fsm #(.CYC_CLKS(CYC_CLKS), .PRE_CLKS(PRE_CLKS)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .any    (any),
        .win    (win),
        .gnt    (gnt),
        .active (mem_strobe)
    );

    always_comb begin
        refresh_cbr = gnt[IDX_REF];
        cpu_rdy     = !(req[IDX_CPU] && !gnt[IDX_CPU]);
    end

    AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_strobe) && !$past(aged)) |->
            (((gnt - NREQ'(1)) & $past(req)) == '0)); // R1

    AST_AGED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_strobe) && $past(aged)) |-> gnt[IDX_REF]); // R7

endmodule

// File: tb/vma_arbiter_bench.sv
`timescale 1ns/1ps
module vma_arbiter_bench;

    localparam int CYC = 3;
    localparam int PRE = 1;
    localparam int AW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    req = '0;
    logic [AW-1:0] lim = 6'd63;
    logic [4:0]    gnt;
    logic          refresh_cbr, cpu_rdy, mem_strobe;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    vma_arbiter #(.CYC_CLKS(CYC), .PRE_CLKS(PRE), .AGE_W(AW)) u_vma_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .age_limit(lim),
        .gnt(gnt), .refresh_cbr(refresh_cbr), .cpu_rdy(cpu_rdy),
        .mem_strobe(mem_strobe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor / scoreboard
    logic prev_strobe = 1'b0;
    logic pend_at_fall = 1'b0;
    int   run_len = 0;
    int   gap_len = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk($onehot0(gnt), "R2 onehot", gnt, 0);
            chk(refresh_cbr == gnt[1], "R5 cbr", refresh_cbr, gnt[1]);
            chk(mem_strobe == (gnt != 0), "R6 strobe", mem_strobe, gnt != 0);
            chk(cpu_rdy == !(req[3] && !gnt[3]), "R4 ready", cpu_rdy, !(req[3] && !gnt[3]));
            if (mem_strobe && !prev_strobe) begin
                if (pend_at_fall)
                    chk(gap_len == PRE, "R3 gap", gap_len, PRE);
                pend_at_fall = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected grant", gnt, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(gnt == (5'b00001 << e), "R1/R7 order", gnt, 1 << e);
                end
                run_len = 1;
            end else if (mem_strobe) begin
                run_len++;
            end else if (prev_strobe) begin
                chk(run_len == CYC, "R3 length", run_len, CYC);
                pend_at_fall = (req != 0);
                gap_len = 1;
            end else begin
                gap_len++;
            end
        end
        prev_strobe = mem_strobe;
    end

    // Driver: raise mask; each requester drops on its first grant,
    // except 'sticky' which drops after sticky_n grants.
    task automatic serve(input logic [4:0] mask, input int sticky, input int sticky_n);
        logic [4:0] last_g;
        int seen;
        last_g = '0;
        seen = 0;
        @(posedge clk); #1;
        req = mask;
        while (req != 0) begin
            @(posedge clk); #1;
            for (int i = 0; i < 5; i++) begin
                if (gnt[i] && !last_g[i]) begin
                    if (i == sticky) begin
                        seen++;
                        if (seen >= sticky_n) req[i] = 1'b0;
                    end else begin
                        req[i] = 1'b0;
                    end
                end
            end
            last_g = gnt;
        end
        while (mem_strobe) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(gnt == 0, "R9 reset gnt", gnt, 0);
        chk(mem_strobe == 0, "R9 reset strobe", mem_strobe, 0);
        chk(refresh_cbr == 0, "R9 reset cbr", refresh_cbr, 0);
        chk(cpu_rdy == 1, "R9 reset ready", cpu_rdy, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gnt == 0, "R9 after reset gnt", gnt, 0);

        // R1: all five at once walk the full order
        lim = 6'd63;
        exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
        exp_q.push_back(3); exp_q.push_back(4);
        serve(5'b11111, -1, 0);

        // R1/R4: processor loses to slow DMA and waits
        exp_q.push_back(2); exp_q.push_back(3);
        serve(5'b01100, -1, 0);

        // R1: processor beats fast DMA
        exp_q.push_back(3); exp_q.push_back(4);
        serve(5'b11000, -1, 0);

        // R1: lone fast DMA
        exp_q.push_back(4);
        serve(5'b10000, -1, 0);

        // R7: no promotion with a high limit
        lim = 6'd63;
        exp_q.push_back(0); exp_q.push_back(0); exp_q.push_back(0); exp_q.push_back(1);
        serve(5'b00011, 0, 3);

        // R7: promotion after waiting 6 clocks
        lim = 6'd6;
        exp_q.push_back(0); exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(0);
        serve(5'b00011, 0, 3);

        // R7: limit 0 promotes at once
        lim = 6'd0;
        exp_q.push_back(1); exp_q.push_back(0);
        serve(5'b00011, -1, 0);

        // R8: idle with no requests
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(gnt == 0 && mem_strobe == 0, "R8 idle", gnt, 0);
        end

        chk(exp_q.size() == 0, "R1 missing grants", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule